// File: doc/BRIEF.md
# Per-Pin Window Comparator Capture Channel

This block holds the digital capture logic for a group of tester pins that run through a numbered sequence of test steps. Every pin feeds two comparator bits into it. One bit reports that the pin is above the upper threshold. The other reports that it is below the lower threshold. A per-step pattern memory supplies two bits for each pin. The direction bit says whether the pin is sensed or driven during the step. The drive bit gives the level to force on driven steps.

A run starts with a start pulse and steps forward once per strobe. On each strobe the block sorts every pin into one of three levels: high, low or in-between. It writes one captured-data bit and one invalid-level bit per pin into a memory slot addressed by the current step. The pin's driver and sense path are tied together, so driven steps are captured too, as a loopback of what the pin actually did. A sticky error bit records that some step saw an in-between level. When the run is idle, a host reads the capture memory by step address and loads the pattern memory.

Top module: `wincap_channel`

## Requirements
- R1: A pin whose high comparator is 1 and low comparator is 0 at the strobe is stored as data 1, invalid flag 0.
- R2: A pin whose high comparator is 0 and low comparator is 1 at the strobe is stored as data 0, invalid flag 0.
- R3: A pin with both comparators 0 (between thresholds) at the strobe is stored as data 0, invalid flag 1.
- R4: A pin with both comparators 1 (impossible ordering) is stored as data 0, invalid flag 1.
- R5: Capture happens only on a strobe pulse while running. Each strobe captures exactly once. The comparator values used are those present in the clock cycle the strobe is high. The memory write and the step increment occur two clock edges after that cycle.
- R6: A start pulse while idle sets busy, sets the step to 0, clears done and latches last_step_i. After the step equal to the latched last step is captured, busy falls and done rises and stays until the next start. Start while busy is ignored.
- R7: While busy, pin_oe_o of a pin is the inverse of its direction bit for the current step (1 = sense, 0 = drive). pin_do_o equals the drive bit on driven pins and 0 on sensed pins. While idle both outputs are all 0.
- R8: Steps whose direction bits mark pins as driven are still captured from the comparators (loopback).
- R9: rd_data_o and rd_inv_o show the capture memory word at rd_addr_i one clock edge after the address is presented. After reset every word reads 0.
- R10: err_o sets when any step is written with any invalid flag at 1. It holds until the next accepted start, which clears it.
- R11: Strobes while idle do not change the capture memory. Pattern writes (cfg_we_i) while busy are ignored. After reset every step's direction bits are all 1 and its drive bits all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-of-run pulse |
| last_step_i | input | AW | Final step index of the run |
| strobe_i | input | 1 | Capture strobe, one pulse per step |
| cmp_hi_i | input | NPINS | Pin above upper threshold, per pin |
| cmp_lo_i | input | NPINS | Pin below lower threshold, per pin |
| cfg_we_i | input | 1 | Pattern memory write enable |
| cfg_addr_i | input | AW | Pattern memory step address |
| cfg_dir_i | input | NPINS | Direction bits to write (1 = sense) |
| cfg_drv_i | input | NPINS | Drive bits to write |
| rd_addr_i | input | AW | Capture memory read address |
| pin_oe_o | output | NPINS | Driver enable per pin |
| pin_do_o | output | NPINS | Driver level per pin |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run completed |
| err_o | output | 1 | Sticky invalid-level seen during run |
| rd_data_o | output | NPINS | Captured data word read back |
| rd_inv_o | output | NPINS | Invalid-flag word read back |

## Verification
The bench presents every comparator pairing, including the impossible one. A design that collapsed the in-between or inverted case to a plain low would report no invalid flag and leave err_o clear. Back-to-back strobes and start pulses arriving mid-run are applied. A sequencer that lost a strobe, counted one twice or restarted would store words at shifted step addresses. Pattern writes during a run and strobes while idle are used to show that neither state changes. A run of length one and a run over the full depth exercise the last-step compare at both extremes.

// File: rtl/wincap_pkg.sv
package wincap_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_HIGH = 2'd1,
    LVL_MID  = 2'd2,
    LVL_BAD  = 2'd3
  } level_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/wincap_sync.sv
module wincap_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/wincap_classify.sv
module wincap_classify
  import wincap_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0] hi_i,
  input  logic [NPINS-1:0] lo_i,
  output logic [NPINS-1:0] data_o,
  output logic [NPINS-1:0] inv_o
);

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    level_e lvl;

    always_comb begin
      unique case ({hi_i[p], lo_i[p]})
        2'b10:   lvl = LVL_HIGH;
        2'b01:   lvl = LVL_LOW;
        2'b00:   lvl = LVL_MID;
        default: lvl = LVL_BAD;
      endcase
    end

    always_comb begin
      data_o[p] = 1'b0;
      inv_o[p]  = 1'b0;
      case (lvl)
        LVL_HIGH: data_o[p] = 1'b1;
        LVL_LOW:  data_o[p] = 1'b0;
        default:  inv_o[p]  = 1'b1;
      endcase
    end

    // R3 / R4: a flagged pin never also reports a 1
    always_comb begin
      a_r3_flag_excludes_one: assert (!(data_o[p] && inv_o[p]));
    end
  end

endmodule

// File: rtl/wincap_stepmem.sv
module wincap_stepmem #(
  parameter int            W       = 8,
  parameter int            DEPTH   = 16,
  parameter bit            REG_RD  = 1'b1,
  parameter logic [W-1:0]  RST_VAL = '0,
  localparam int           AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= RST_VAL;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  if (REG_RD) begin : g_reg_rd
    logic [W-1:0] rd_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= RST_VAL;
      else        rd_q <= mem_q[raddr_i];
    end
    assign rdata_o = rd_q;
  end else begin : g_comb_rd
    assign rdata_o = mem_q[raddr_i];
  end

endmodule

// File: rtl/wincap_seq.sv
module wincap_seq
  import wincap_pkg::*;
#(
  parameter int  DEPTH = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] last_i,
  input  logic          cap_en_i,
  input  logic          inv_any_i,
  output logic          busy_o,
  output logic [AW-1:0] step_o,
  output logic          done_o,
  output logic          err_o,
  output logic          wr_o
);

  seq_state_e    state_q, state_d;
  logic [AW-1:0] step_q, step_d;
  logic [AW-1:0] last_q, last_d;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic          wr;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    last_d  = last_q;
    done_d  = done_q;
    err_d   = err_q;
    wr      = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (start_i) begin
          state_d = SEQ_RUN;
          step_d  = '0;
          last_d  = last_i;
          done_d  = 1'b0;
          err_d   = 1'b0;
        end
      end
      default: begin
        if (cap_en_i) begin
          wr = 1'b1;
          if (inv_any_i) err_d = 1'b1;
          if (step_q == last_q) begin
            state_d = SEQ_IDLE;
            done_d  = 1'b1;
          end else begin
            step_d = step_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      step_q  <= '0;
      last_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      last_q  <= last_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign busy_o = (state_q == SEQ_RUN);
  assign step_o = step_q;
  assign done_o = done_q;
  assign err_o  = err_q;
  assign wr_o   = wr;

  // R5: a strobe short of the last step moves the step on by exactly one
  a_r5_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cap_en_i && step_o != last_q) |=> (busy_o && step_o == $past(step_o) + 1'b1));

  // R5: no strobe, no movement
  a_r5_step_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !cap_en_i) |=> (busy_o && $stable(step_o)));

  // R6: the last capture ends the run
  a_r6_done_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cap_en_i && step_o == last_q) |=> (!busy_o && done_o));

  // R6: an accepted start resets step and status
  a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && step_o == '0 && !done_o && !err_o));

  // R10: an invalid write raises the error bit
  a_r10_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_o && inv_any_i) |=> err_o);

  // R10: the error bit is sticky until a start
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !start_i) |=> err_o);

endmodule

// File: rtl/wincap_channel.sv
module wincap_channel #(
  parameter int  NPINS = 32,
  parameter int  DEPTH = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [AW-1:0]    last_step_i,
  input  logic             strobe_i,
  input  logic [NPINS-1:0] cmp_hi_i,
  input  logic [NPINS-1:0] cmp_lo_i,
  input  logic             cfg_we_i,
  input  logic [AW-1:0]    cfg_addr_i,
  input  logic [NPINS-1:0] cfg_dir_i,
  input  logic [NPINS-1:0] cfg_drv_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [NPINS-1:0] pin_oe_o,
  output logic [NPINS-1:0] pin_do_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [NPINS-1:0] rd_data_o,
  output logic [NPINS-1:0] rd_inv_o
);

  localparam int SW = 2 * NPINS + 1;
  localparam int MW = 2 * NPINS;
  localparam logic [MW-1:0] PAT_RST = {{NPINS{1'b1}}, {NPINS{1'b0}}};

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_core_n <= rst_meta_n;
    end
  end

  logic [SW-1:0]    sync_q;
  logic             strb_s;
  logic [NPINS-1:0] hi_s, lo_s;
  logic [NPINS-1:0] cap_data, cap_inv;
  logic [AW-1:0]    step;
  logic             busy, wr;
  logic [MW-1:0]    rd_word, pat_word;
  logic [NPINS-1:0] pat_dir, pat_drv;
  logic             cfg_wr_en;

  wincap_sync #(.W(SW)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d_i   ({strobe_i, cmp_hi_i, cmp_lo_i}),
    .q_o   (sync_q)
  );

  assign strb_s = sync_q[SW-1];
  assign hi_s   = sync_q[MW-1:NPINS];
  assign lo_s   = sync_q[NPINS-1:0];

  wincap_classify #(.NPINS(NPINS)) u_cls (
    .hi_i   (hi_s),
    .lo_i   (lo_s),
    .data_o (cap_data),
    .inv_o  (cap_inv)
  );

  wincap_seq #(.DEPTH(DEPTH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .start_i   (start_i),
    .last_i    (last_step_i),
    .cap_en_i  (strb_s),
    .inv_any_i (|cap_inv),
    .busy_o    (busy),
    .step_o    (step),
    .done_o    (done_o),
    .err_o     (err_o),
    .wr_o      (wr)
  );

  wincap_stepmem #(.W(MW), .DEPTH(DEPTH), .REG_RD(1'b1), .RST_VAL('0)) u_capmem (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .we_i    (wr),
    .waddr_i (step),
    .wdata_i ({cap_inv, cap_data}),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_word)
  );

  assign cfg_wr_en = cfg_we_i & ~busy;

  wincap_stepmem #(.W(MW), .DEPTH(DEPTH), .REG_RD(1'b0), .RST_VAL(PAT_RST)) u_patmem (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .we_i    (cfg_wr_en),
    .waddr_i (cfg_addr_i),
    .wdata_i ({cfg_dir_i, cfg_drv_i}),
    .raddr_i (step),
    .rdata_o (pat_word)
  );

  assign pat_dir   = pat_word[MW-1:NPINS];
  assign pat_drv   = pat_word[NPINS-1:0];
  assign rd_inv_o  = rd_word[MW-1:NPINS];
  assign rd_data_o = rd_word[NPINS-1:0];
  assign busy_o    = busy;
  assign pin_oe_o  = busy ? ~pat_dir : '0;
  assign pin_do_o  = busy ? (pat_drv & ~pat_dir) : '0;

  // R7: a sensed pin is never driven high
  a_r7_no_drive_when_off: assert property (@(posedge clk) disable iff (!rst_core_n)
    (pin_do_o & ~pin_oe_o) == '0);

  // R6: done and busy are never both raised
  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(done_o && busy_o));

endmodule

// File: tb/wincap_channel_tb_top.sv
module wincap_channel_tb_top;

  localparam int NP    = 32;
  localparam int DEPTH = 16;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [AW-1:0] last_step_i;
  logic          strobe_i;
  logic [NP-1:0] cmp_hi_i, cmp_lo_i;
  logic          cfg_we_i;
  logic [AW-1:0] cfg_addr_i;
  logic [NP-1:0] cfg_dir_i, cfg_drv_i;
  logic [AW-1:0] rd_addr_i;
  logic [NP-1:0] pin_oe_o, pin_do_o, rd_data_o, rd_inv_o;
  logic          busy_o, done_o, err_o;

  wincap_channel dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .last_step_i(last_step_i),
    .strobe_i(strobe_i), .cmp_hi_i(cmp_hi_i), .cmp_lo_i(cmp_lo_i),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_dir_i(cfg_dir_i),
    .cfg_drv_i(cfg_drv_i), .rd_addr_i(rd_addr_i), .pin_oe_o(pin_oe_o),
    .pin_do_o(pin_do_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .rd_data_o(rd_data_o), .rd_inv_o(rd_inv_o)
  );

  always #5 clk = ~clk;

  int vectors = 0;
  int fails   = 0;

  task automatic chk(string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit            m_run, m_done, m_err;
  int            m_step, m_last;
  logic [NP-1:0] m_cd [DEPTH];
  logic [NP-1:0] m_ci [DEPTH];
  logic [NP-1:0] m_dir [DEPTH];
  logic [NP-1:0] m_drv [DEPTH];
  logic [NP-1:0] m_rdd, m_rdi;
  logic [2*NP:0] hist [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_done = 0; m_err = 0; m_step = 0; m_last = 0;
      m_rdd = '0; m_rdi = '0;
      hist.delete();
      for (int i = 0; i < DEPTH; i++) begin
        m_cd[i] = '0; m_ci[i] = '0; m_dir[i] = '1; m_drv[i] = '0;
      end
    end else begin
      logic [2*NP:0] old;
      logic [NP-1:0] nrd, nri, hi, lo, dv, iv;
      old = (hist.size() == 2) ? hist.pop_front() : '0;
      nrd = m_cd[rd_addr_i];
      nri = m_ci[rd_addr_i];
      if (!m_run) begin
        if (cfg_we_i) begin
          m_dir[cfg_addr_i] = cfg_dir_i;
          m_drv[cfg_addr_i] = cfg_drv_i;
        end
        if (start_i) begin
          m_run = 1; m_step = 0; m_done = 0; m_err = 0; m_last = int'(last_step_i);
        end
      end else if (old[2*NP]) begin
        hi = old[2*NP-1:NP];
        lo = old[NP-1:0];
        for (int p = 0; p < NP; p++) begin
          if (hi[p] && !lo[p])      begin dv[p] = 1'b1; iv[p] = 1'b0; end
          else if (!hi[p] && lo[p]) begin dv[p] = 1'b0; iv[p] = 1'b0; end
          else                      begin dv[p] = 1'b0; iv[p] = 1'b1; end
        end
        m_cd[m_step] = dv;
        m_ci[m_step] = iv;
        if (iv != '0) m_err = 1;
        if (m_step == m_last) begin m_run = 0; m_done = 1; end
        else m_step++;
      end
      hist.push_back({strobe_i, cmp_hi_i, cmp_lo_i});
      m_rdd = nrd;
      m_rdi = nri;
    end
  end

  // per-cycle comparison, away from the active edge
  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R6 busy", NP'(busy_o), NP'(m_run));
      chk("R6 done", NP'(done_o), NP'(m_done));
      chk("R10 err", NP'(err_o), NP'(m_err));
      chk("R7 oe", pin_oe_o, m_run ? ~m_dir[m_step] : '0);
      chk("R7 do", pin_do_o, m_run ? (m_drv[m_step] & ~m_dir[m_step]) : '0);
      chk("R9 rd_data", rd_data_o, m_rdd);
      chk("R9 rd_inv", rd_inv_o, m_rdi);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start(int last);
    start_i = 1'b1; last_step_i = AW'(last);
    cyc(1);
    start_i = 1'b0;
  endtask

  task automatic do_strobe(logic [NP-1:0] hi, logic [NP-1:0] lo, int gap);
    cmp_hi_i = hi; cmp_lo_i = lo; strobe_i = 1'b1;
    cyc(1);
    strobe_i = 1'b0;
    cyc(gap);
  endtask

  task automatic read_word(int a, logic [NP-1:0] ed, logic [NP-1:0] ei, string tag);
    rd_addr_i = AW'(a);
    cyc(1);
    chk(tag, rd_data_o, ed);
    chk(tag, rd_inv_o, ei);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 0; last_step_i = '0; strobe_i = 0;
    cmp_hi_i = '0; cmp_lo_i = '0; cfg_we_i = 0; cfg_addr_i = '0;
    cfg_dir_i = '0; cfg_drv_i = '0; rd_addr_i = '0;
    cyc(4);
    rst_n = 1'b1;
    cyc(4);
    // reset state: R6 idle, R7 tri-state, R9 zeroed memory
    chk("R6 reset busy", NP'(busy_o), '0);
    chk("R7 reset oe", pin_oe_o, '0);
    chk("R9 reset rd", rd_data_o | rd_inv_o, '0);
    cmp_on = 1;

    // pattern load (R11 defaults overwritten): steps 1 and 3 driven
    for (int s = 0; s < DEPTH; s++) begin
      cfg_we_i = 1; cfg_addr_i = AW'(s);
      cfg_dir_i = (s % 2 == 1) ? 32'h0000_0000 : 32'hFFFF_0000;
      cfg_drv_i = 32'hA5A5_5A5A ^ NP'(s);
      cyc(1);
    end
    cfg_we_i = 0;

    // run A: one step per comparator pairing (R1 R2 R3 R4 R8)
    do_start(3);
    chk("R7 oe step0", pin_oe_o, 32'h0000_FFFF);
    do_strobe('1, '0, 3);
    chk("R7 oe step1 driven", pin_oe_o, '1);
    do_strobe('0, '1, 3);
    do_strobe('0, '0, 3);
    do_strobe('1, '1, 3);
    chk("R6 done after last", NP'(done_o), NP'(1));
    chk("R10 err after mid", NP'(err_o), NP'(1));
    read_word(0, '1, '0, "R1 high");
    read_word(1, '0, '0, "R2 low R8 loopback");
    read_word(2, '0, '1, "R3 between");
    read_word(3, '0, '1, "R4 both");

    // R11: strobes while idle leave memory alone
    do_strobe(32'h1234_5678, '0, 1);
    do_strobe('1, '0, 4);
    read_word(0, '1, '0, "R11 idle strobe");
    read_word(2, '0, '1, "R11 idle strobe");

    // run B: single step, err cleared on start (R10, R6)
    do_start(0);
    chk("R10 err cleared", NP'(err_o), '0);
    do_strobe(32'h0F0F_0F0F, 32'hF0F0_F0F0, 3);
    chk("R10 err stays clear", NP'(err_o), '0);
    chk("R6 single step done", NP'(done_o), NP'(1));
    read_word(0, 32'h0F0F_0F0F, '0, "R1 R2 mixed");

    // run C: full depth, random data, mid-run start and cfg writes (R5 R11)
    do_start(DEPTH - 1);
    for (int s = 0; s < DEPTH; s++) begin
      logic [NP-1:0] h, l;
      h = $urandom(); l = $urandom() & ~h;
      if (s == 5) l = $urandom();
      if (s == 7) begin cfg_we_i = 1; cfg_addr_i = AW'(8); cfg_dir_i = '0; cfg_drv_i = '1; end
      if (s == 9) start_i = 1;
      do_strobe(h, l, (s % 4 == 0) ? 0 : s % 3 + 1);
      cfg_we_i = 0; start_i = 0;
      cyc($urandom_range(0, 3));
    end
    cyc(4);
    chk("R5 full run done", NP'(done_o), NP'(1));
    for (int s = 0; s < DEPTH; s++) begin
      rd_addr_i = AW'(s);
      cyc(1);
    end

    // run D: R5 strobe held off, no advance; then two runs of back-to-back strobes
    do_start(2);
    cyc(10);
    chk("R5 no strobe no advance", pin_oe_o, 32'h0000_FFFF);
    do_strobe(32'hFFFF_0000, 32'h0000_FFFF, 0);
    do_strobe(32'h00FF_0000, 32'h0000_00FF, 0);
    do_strobe(32'h3333_3333, 32'hCCCC_CCCC, 4);
    read_word(1, 32'h00FF_0000, 32'hFF00_FF00, "R5 back-to-back");
    read_word(2, 32'h3333_3333, '0, "R5 back-to-back");
    cyc(3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule